// File: doc/BRIEF.md
# Flash Command Sequence Interpreter

This block sits at the pin boundary of a NOR-style flash model. It sorts the asynchronous chip-enable, output-enable, write-enable and reset pins into bus cycles (read, command write, standby, output disable) and follows the multi-write unlock sequences that select a mode. The mode can be read-array, identification (autoselect), program, erase or a shortened program mode called unlock bypass. All pins, the address and the data are brought into the system clock domain through a two-flop synchroniser. A command is taken on the rising edge of write enable.

The outputs are one-cycle program and erase requests, which carry the captured address and data. There is also a read-path enable, and a flag that steers reads to the identification register instead of the array. A level flag for the accelerate pin forces unlock bypass while it is held. The same flag also reports that every sector counts as unprotected. An array stub or a timing model downstream consumes the requests.

Top module: `flash_cmd_seq`

## Requirements
- R1: After system reset, and with no command written, a read cycle enables the output path (`dout_en`=1) and `autosel_rd` stays 0, so reads go to the array.
- R2: `dout_en` is 1 only while `ce_n`=0, `oe_n`=0, `we_n`=1 and `hw_rst_n`=1.
- R3: With `ce_n`=1 and `hw_rst_n`=1 (standby), `dout_en` is 0 whatever the level of `oe_n`.
- R4: A write is taken only on a rising edge of `we_n` while `ce_n`=0 and `oe_n`=1. A write pulse with `oe_n`=0 has no effect on the sequence.
- R5: The four writes 0xAA@0x555, 0x55@0x2AA, 0xA0@0x555 and then data@address give exactly one `prog_req` pulse, with `op_addr`/`op_data` holding that address and data.
- R6: The writes 0xAA@0x555, 0x55@0x2AA, 0x80@0x555, 0xAA@0x555, 0x55@0x2AA and then 0x30@sector give one `erase_req` pulse with `erase_all`=0 and `op_addr`=sector. If the last write is 0x10@0x555 instead, the pulse comes with `erase_all`=1. `prog_req` and `erase_req` are never high together.
- R7: The unlock pair followed by 0x90@0x555 makes read cycles raise `autosel_rd`. A later write returns reads to the array.
- R8: A write that does not match the expected next step returns the interpreter to read-array. A later data write then produces no request.
- R9: A write of 0xF0 returns to read-array from any state except a program data cycle, where it is taken as data.
- R10: The unlock pair followed by 0x20@0x555 enters unlock bypass. There, 0xA0 and then data@address give a `prog_req` pulse each time. Other writes leave the mode unchanged. The writes 0x90 and then 0x00 leave the mode.
- R11: While `accel`=1 the interpreter is in unlock bypass and `unprot`=1. When `accel` returns to 0, it goes back to read-array.
- R12: `hw_rst_n`=0 returns the interpreter to read-array from any mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | System reset, active low, asynchronous |
| ce_n | input | 1 | Chip enable pin, active low |
| oe_n | input | 1 | Output enable pin, active low |
| we_n | input | 1 | Write enable pin, active low |
| hw_rst_n | input | 1 | Hardware reset pin, active low |
| accel | input | 1 | Accelerate pin level flag |
| addr | input | AW | Address pins |
| wdata | input | DW | Data pins (write side) |
| dout_en | output | 1 | Read path drives the data pins |
| autosel_rd | output | 1 | Current read is from the identification register |
| unprot | output | 1 | All sectors treated as unprotected |
| prog_req | output | 1 | One-cycle program request |
| erase_req | output | 1 | One-cycle erase request |
| erase_all | output | 1 | Erase request covers the whole device |
| op_addr | output | AW | Address of the request |
| op_data | output | DW | Data of the program request |

## Verification
The assertions check on every cycle that standby never enables the output path and that the two requests never coincide. They also check that a program request always follows a taken write edge, that a held accelerate flag keeps the interpreter in bypass, that the hardware reset pin forces read-array, and that identification reads happen only during a read cycle. Only the bench scenarios can show that the sequences work end to end. These are the four-write and two-write programs, both erase variants, autoselect entry and exit, aborted sequences, 0xF0 taken as data in a data cycle, and writes ignored with output enable low.

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq #(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic          hw_rst_n,
  input  logic          accel,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          dout_en,
  output logic          autosel_rd,
  output logic          unprot,
  output logic          prog_req,
  output logic          erase_req,
  output logic          erase_all,
  output logic [AW-1:0] op_addr,
  output logic [DW-1:0] op_data
);

  typedef enum logic [3:0] {RD, C1, C2, ASEL, PGM, ES, E1, E2, BYP, BPGM, BEXIT} st_t;

  localparam logic [4:0] PIN_IDLE = 5'b01111;

  st_t st, nxt;
  logic [4:0] p1, p2, p3;
  logic [AW-1:0] a1, a2;
  logic [DW-1:0] d1, d2;
  logic fire_p, fire_e, all_e;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      p1 <= PIN_IDLE; p2 <= PIN_IDLE; p3 <= PIN_IDLE;
      a1 <= '0; a2 <= '0; d1 <= '0; d2 <= '0;
    end else begin
      p1 <= {accel, hw_rst_n, oe_n, ce_n, we_n};
      p2 <= p1; p3 <= p2;
      a1 <= addr; a2 <= a1;
      d1 <= wdata; d2 <= d1;
    end

  wire        we_rise  = p2[0] & ~p3[0] & ~p3[1] & p3[2];
  wire        acc      = p2[4];
  wire        acc_fall = p3[4] & ~p2[4];
  wire        rp_ok    = p2[3];
  wire [7:0]  cmd      = d2[7:0];
  wire [10:0] a11      = a2[10:0];
  wire        is_u1    = cmd == 8'hAA && a11 == 11'h555;
  wire        is_u2    = cmd == 8'h55 && a11 == 11'h2AA;

  function automatic logic in_byp(st_t s);
    return s == BYP || s == BPGM || s == BEXIT;
  endfunction

  always_comb begin
    nxt = st; fire_p = 1'b0; fire_e = 1'b0; all_e = 1'b0;
    if (we_rise) begin
      case (st)
        RD, ASEL: nxt = is_u1 ? C1 : RD;
        C1:       nxt = is_u2 ? C2 : RD;
        C2: begin
          nxt = RD;
          if (a11 == 11'h555)
            case (cmd)
              8'hA0:   nxt = PGM;
              8'h80:   nxt = ES;
              8'h90:   nxt = ASEL;
              8'h20:   nxt = BYP;
              default: nxt = RD;
            endcase
        end
        PGM:      begin fire_p = 1'b1; nxt = RD; end
        ES:       nxt = is_u1 ? E1 : RD;
        E1:       nxt = is_u2 ? E2 : RD;
        E2: begin
          nxt = RD;
          if (cmd == 8'h30) fire_e = 1'b1;
          else if (cmd == 8'h10 && a11 == 11'h555) begin fire_e = 1'b1; all_e = 1'b1; end
        end
        BYP:      nxt = cmd == 8'hA0 ? BPGM : (cmd == 8'h90 ? BEXIT : BYP);
        BPGM:     begin fire_p = 1'b1; nxt = BYP; end
        BEXIT:    nxt = cmd == 8'h00 ? RD : BYP;
        default:  nxt = RD;
      endcase
      if (cmd == 8'hF0 && st != PGM && st != BPGM) nxt = RD;
    end
    if (acc && !in_byp(nxt)) nxt = BYP;
    if (acc_fall) nxt = RD;
    if (!rp_ok) begin nxt = RD; fire_p = 1'b0; fire_e = 1'b0; end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= RD; prog_req <= 1'b0; erase_req <= 1'b0; erase_all <= 1'b0;
      op_addr <= '0; op_data <= '0;
    end else begin
      st <= nxt;
      prog_req <= fire_p;
      erase_req <= fire_e;
      if (fire_p || fire_e) begin
        op_addr <= a2; op_data <= d2; erase_all <= all_e;
      end
    end

  assign dout_en    = ~ce_n & ~oe_n & we_n & hw_rst_n;
  assign autosel_rd = dout_en & (st == ASEL);
  assign unprot     = acc;

  wire byp_now = in_byp(st);

  a_r3_standby_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n && hw_rst_n) |-> !dout_en);
  a_r5_prog_after_edge: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req |-> $past(we_rise));
  a_r6_req_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(prog_req && erase_req));
  a_r11_accel_holds_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && rp_ok) |=> byp_now);
  a_r12_pin_reset_read: assert property (@(posedge clk) disable iff (!rst_n)
    !rp_ok |=> (st == RD));
  a_r7_id_only_in_read: assert property (@(posedge clk) disable iff (!rst_n)
    autosel_rd |-> dout_en);

endmodule

// File: tb/sim_flash_cmd_seq.sv
module sim_flash_cmd_seq;
  localparam int AW = 20, DW = 16;
  logic clk = 0, rst_n = 0;
  logic ce_n = 1, oe_n = 1, we_n = 1, hw_rst_n = 1, accel = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic dout_en, autosel_rd, unprot, prog_req, erase_req, erase_all;
  logic [AW-1:0] op_addr;
  logic [DW-1:0] op_data;
  int total = 0, bad = 0, np = 0, ne = 0, both = 0;
  logic [AW-1:0] last_a; logic [DW-1:0] last_d; logic last_all;

  always #4 clk = ~clk;

  flash_cmd_seq #(.AW(AW), .DW(DW)) u0 (.*);

  always @(negedge clk) begin
    if (prog_req) begin np++; last_a = op_addr; last_d = op_data; end
    if (erase_req) begin ne++; last_a = op_addr; last_all = erase_all; end
    if (prog_req && erase_req) both++;
  end

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin bad++; $display("FAIL %s actual=%0h expected=%0h", r, act, exp); end
  endtask

  task automatic cyc(int n); repeat (n) @(negedge clk); endtask

  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d, logic oe = 1);
    addr = a; wdata = d; oe_n = oe; ce_n = 0; cyc(3);
    we_n = 0; cyc(3); we_n = 1; cyc(5); ce_n = 1; oe_n = 1; cyc(1);
  endtask

  task automatic unlock(); wr(20'h555, 16'hAA); wr(20'h2AA, 16'h55); endtask

  task automatic rd_check(string r, logic exp_en, logic exp_id);
    ce_n = 0; oe_n = 0; cyc(1);
    chk({r, " dout_en"}, dout_en, exp_en);
    chk({r, " autosel_rd"}, autosel_rd, exp_id);
    oe_n = 1; ce_n = 1; cyc(1);
  endtask

  task automatic t_reset_read();
    rd_check("R1", 1, 0);
    chk("R1 prog_req", prog_req, 0);
  endtask

  task automatic t_bus_decode();
    ce_n = 0; oe_n = 0; we_n = 0; cyc(1); chk("R2 we low", dout_en, 0);
    we_n = 1; hw_rst_n = 0; cyc(1); chk("R2 reset pin low", dout_en, 0);
    hw_rst_n = 1; oe_n = 1; cyc(1); chk("R2 oe high", dout_en, 0);
    ce_n = 1; oe_n = 0; cyc(1); chk("R3 standby oe low", dout_en, 0);
    oe_n = 1; cyc(1); chk("R3 standby oe high", dout_en, 0);
    cyc(5);
  endtask

  task automatic t_program();
    int p0 = np;
    unlock(); wr(20'h555, 16'hA0); wr(20'h1234, 16'hBEEF);
    chk("R5 pulses", np - p0, 1);
    chk("R5 addr", last_a, 20'h1234);
    chk("R5 data", last_d, 16'hBEEF);
    rd_check("R5 back to array", 1, 0);
  endtask

  task automatic t_oe_low_ignored();
    int p0 = np;
    wr(20'h555, 16'hAA, 0); wr(20'h2AA, 16'h55); wr(20'h555, 16'hA0); wr(20'h40, 16'h1111);
    chk("R4 write with oe low ignored", np - p0, 0);
  endtask

  task automatic t_erase();
    int e0 = ne;
    unlock(); wr(20'h555, 16'h80); unlock(); wr(20'h30000, 16'h30);
    chk("R6 sector erase pulse", ne - e0, 1);
    chk("R6 sector addr", last_a, 20'h30000);
    chk("R6 sector not all", last_all, 0);
    unlock(); wr(20'h555, 16'h80); unlock(); wr(20'h555, 16'h10);
    chk("R6 chip erase pulse", ne - e0, 2);
    chk("R6 chip erase all", last_all, 1);
    chk("R6 never both", both, 0);
  endtask

  task automatic t_autoselect();
    unlock(); wr(20'h555, 16'h90);
    rd_check("R7 id read", 1, 1);
    wr(20'h0, 16'hF0);
    rd_check("R7 exit to array", 1, 0);
  endtask

  task automatic t_broken();
    int p0 = np;
    wr(20'h555, 16'hAA); wr(20'h2AB, 16'h55); wr(20'h555, 16'hA0); wr(20'h77, 16'h2222);
    chk("R8 bad address aborts", np - p0, 0);
    unlock(); wr(20'h555, 16'h33); wr(20'h77, 16'h2222);
    chk("R8 bad command aborts", np - p0, 0);
  endtask

  task automatic t_f0();
    int p0 = np;
    wr(20'h555, 16'hAA); wr(20'h0, 16'hF0); wr(20'h2AA, 16'h55); wr(20'h555, 16'hA0); wr(20'h9, 16'h3);
    chk("R9 F0 aborts unlock", np - p0, 0);
    unlock(); wr(20'h555, 16'hA0); wr(20'h88, 16'h00F0);
    chk("R9 F0 as program data", np - p0, 1);
    chk("R9 data value", last_d, 16'h00F0);
  endtask

  task automatic t_bypass();
    int p0 = np;
    unlock(); wr(20'h555, 16'h20);
    wr(20'h0, 16'hA0); wr(20'h100, 16'h5A5A);
    chk("R10 two-write program", np - p0, 1);
    chk("R10 addr", last_a, 20'h100);
    wr(20'h3, 16'h44);
    wr(20'h0, 16'hA0); wr(20'h104, 16'h6B6B);
    chk("R10 other write keeps bypass", np - p0, 2);
    chk("R10 data", last_d, 16'h6B6B);
    wr(20'h0, 16'h90); wr(20'h0, 16'h00);
    wr(20'h0, 16'hA0); wr(20'h108, 16'h7);
    chk("R10 exit sequence", np - p0, 2);
  endtask

  task automatic t_accel();
    int p0 = np;
    accel = 1; cyc(4);
    chk("R11 unprot", unprot, 1);
    wr(20'h0, 16'hA0); wr(20'h200, 16'h1357);
    chk("R11 bypass while accel", np - p0, 1);
    chk("R11 data", last_d, 16'h1357);
    accel = 0; cyc(4);
    chk("R11 unprot off", unprot, 0);
    wr(20'h0, 16'hA0); wr(20'h204, 16'h2468);
    chk("R11 normal after release", np - p0, 1);
  endtask

  task automatic t_hw_reset();
    unlock(); wr(20'h555, 16'h90);
    rd_check("R12 in autoselect", 1, 1);
    hw_rst_n = 0; cyc(4); hw_rst_n = 1; cyc(4);
    rd_check("R12 after pin reset", 1, 0);
  endtask

  initial begin
    cyc(3); rst_n = 1; cyc(3);
    t_reset_read();
    t_bus_decode();
    t_program();
    t_oe_low_ignored();
    t_erase();
    t_autoselect();
    t_broken();
    t_f0();
    t_bypass();
    t_accel();
    t_hw_reset();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule